// File: doc/BRIEF.md
# SMBus Alert Responder

This block lets a device flag a pending, unmasked interrupt to the bus host through an active-low alert line, and answer the host's alert response query. While alert mode is on and an interrupt is pending, the block pulls the alert line low. The host then reads from the fixed alert response address 0001100b. The bus interface decodes that address byte and hands it to the block. If the block is driving the alert line at that moment, it asks the bus interface to acknowledge the byte and to return the device's own address as the reply.

Once the host acknowledges that reply byte, the block lets go of the alert line. It will not pull the line again until the pending condition has gone away and then come back. The bit-level bus engine and bus arbitration sit outside this block. The block sees the bus only as a decoded stream of single-cycle events.

Top module: `smb_alert_resp`

## Requirements
- R1: After reset, `alert_n` is 1, `ack_req` is 0 and `reply_byte` is 0.
- R2: With `alert_en` at 1 and the block idle, `irq_pending` at 1 drives `alert_n` to 0 one clock later.
- R3: While `alert_en` is 0, `alert_n` stays 1 and `ack_req` never rises, even when an alert response read arrives.
- R4: While the block drives the alert line, an address byte of 8'h19 (address 0001100b in bits 7:1, bit 0 = 1 for read) raises `ack_req` one clock later. During that time `reply_byte` equals the own address in bits 7:1, with bit 0 = 0.
- R5: An address byte of 8'h18 (a write to the alert response address) or any other address is ignored: `ack_req` stays 0 and `alert_n` is unchanged.
- R6: An alert response read is never acknowledged while the block is not driving the alert line, either because it is idle or because it has already released the line.
- R7: A completed reply (`ev_reply_done`) with `ev_reply_acked` = 1 releases the alert line and clears `ack_req` one clock later.
- R8: A reply that the host does not acknowledge, or a start or stop before the reply completes, clears `ack_req` one clock later while `alert_n` stays 0.
- R9: After a release, `alert_n` stays 1 while `irq_pending` remains 1. It returns to 0 only after `irq_pending` has gone to 0 and then back to 1.
- R10: If `irq_pending` falls while the block is alerting and no response is in progress, `alert_n` returns to 1 one clock later.
- R11: Clearing `alert_en` during an alert or a response releases `alert_n` and clears `ack_req` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alert_en | input | 1 | Alert mode enable (control register bit 6) |
| irq_pending | input | 1 | An unmasked interrupt condition is pending |
| own_addr | input | 7 | Device's own bus address |
| ev_start | input | 1 | Pulse: start or repeated start seen on the bus |
| ev_stop | input | 1 | Pulse: stop seen on the bus |
| ev_addr_vld | input | 1 | Pulse: an address byte has been received |
| ev_addr_byte | input | 8 | Received address byte (address in 7:1, R/W in 0) |
| ev_reply_done | input | 1 | Pulse: the reply byte has been sent and its ACK bit sampled |
| ev_reply_acked | input | 1 | Host acknowledged the reply byte (valid with ev_reply_done) |
| alert_n | output | 1 | Active-low alert line |
| ack_req | output | 1 | Request: acknowledge the address and return the reply byte |
| reply_byte | output | 8 | Byte to return during the alert response |

## Verification
The bench targets several corner cases, each tied to a specific way the design could go wrong. A write to the alert response address must be ignored; a design that ignores the R/W bit would acknowledge it. A device that has already released the line must stay silent when the host repeats the query; a design without a released state would answer twice and re-raise the alert while the pending condition is still held. The bench also aborts responses with a NACK, a stop or a repeated start; a design that got this wrong would either drop the alert for good or keep requesting an ACK. Finally, it toggles the enable mid-response, which catches a design that keeps acknowledging after alert mode is turned off.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALERT = 2'd1,
        ST_RESP  = 2'd2,
        ST_HOLD  = 2'd3
    } sar_state_e;

    typedef struct packed {
        sar_state_e state;
        logic       alert;
        logic       ack_req;
    } sar_regs_t;
endpackage

// File: rtl/sar_ara_decode.sv
module sar_ara_decode #(
    parameter int          ADDR_W   = 7,
    parameter logic [6:0]  ARA_ADDR = 7'b0001100
) (
    input  logic            addr_vld,
    input  logic [ADDR_W:0] addr_byte,
    output logic            ara_rd
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(ARA_ADDR);

    always_comb begin
        ara_rd = addr_vld && (addr_byte[ADDR_W:1] == MATCH) && addr_byte[0];
    end
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alert_en,
    input  logic irq_pending,
    input  logic ara_rd,
    input  logic ev_addr_vld,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_reply_done,
    input  logic ev_reply_acked,
    output logic alert_q,
    output logic ack_req_q
);
    sar_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (alert_en && irq_pending) r_d.state = ST_ALERT;
            end
            ST_ALERT: begin
                if (!alert_en || !irq_pending) r_d.state = ST_IDLE;
                else if (ara_rd)               r_d.state = ST_RESP;
            end
            ST_RESP: begin
                if (!alert_en)                r_d.state = ST_IDLE;
                else if (ev_reply_done)       r_d.state = ev_reply_acked ? ST_HOLD : ST_ALERT;
                else if (ev_start || ev_stop) r_d.state = ST_ALERT;
            end
            ST_HOLD: begin
                if (!irq_pending) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.alert   = (r_d.state == ST_ALERT) || (r_d.state == ST_RESP);
        r_d.ack_req = (r_d.state == ST_RESP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, alert: 1'b0, ack_req: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign alert_q   = r_q.alert;
    assign ack_req_q = r_q.ack_req;

    AST_ASSERT_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && alert_en && irq_pending) |=> alert_q); // R2
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_en |=> (!alert_q && !ack_req_q)); // R3
    AST_ARA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_q && !ack_req_q && alert_en && irq_pending && ara_rd) |=> ack_req_q); // R4
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_req_q && ev_addr_vld && !ara_rd) |=> !ack_req_q); // R5
    AST_NO_ACK_UNALERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!alert_q && !ack_req_q) |=> !ack_req_q); // R6
    AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_q && ev_reply_done && ev_reply_acked) |=> (!alert_q && !ack_req_q)); // R7
    AST_ABORT_KEEPS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req_q && alert_en && !ev_reply_done && (ev_start || ev_stop)) |=> (alert_q && !ack_req_q)); // R8
    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD && irq_pending) |=> !alert_q); // R9
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ALERT && !irq_pending) |=> !alert_q); // R10
endmodule

// File: rtl/sar_reply_fmt.sv
module sar_reply_fmt #(
    parameter int   ADDR_W    = 7,
    parameter logic REPLY_LSB = 1'b0
) (
    input  logic              ack_req,
    input  logic [ADDR_W-1:0] own_addr,
    output logic [ADDR_W:0]   reply_byte
);
    always_comb begin
        reply_byte = ack_req ? {own_addr, REPLY_LSB} : '0;
    end
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
    parameter int         ADDR_W   = 7,
    parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alert_en,
    input  logic              irq_pending,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_addr_vld,
    input  logic [ADDR_W:0]   ev_addr_byte,
    input  logic              ev_reply_done,
    input  logic              ev_reply_acked,
    output logic              alert_n,
    output logic              ack_req,
    output logic [ADDR_W:0]   reply_byte
);
    logic ara_rd;
    logic alert_q;

    sar_ara_decode #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_dec (
        .addr_vld  (ev_addr_vld),
        .addr_byte (ev_addr_byte),
        .ara_rd    (ara_rd)
    );

    sar_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .alert_en       (alert_en),
        .irq_pending    (irq_pending),
        .ara_rd         (ara_rd),
        .ev_addr_vld    (ev_addr_vld),
        .ev_start       (ev_start),
        .ev_stop        (ev_stop),
        .ev_reply_done  (ev_reply_done),
        .ev_reply_acked (ev_reply_acked),
        .alert_q        (alert_q),
        .ack_req_q      (ack_req)
    );

    sar_reply_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .ack_req    (ack_req),
        .own_addr   (own_addr),
        .reply_byte (reply_byte)
    );

    assign alert_n = ~alert_q;

    AST_ACK_ONLY_ALERTING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> !alert_n); // R6
endmodule

// File: tb/tb_smb_alert_resp.sv
`timescale 1ns/1ps
module tb_smb_alert_resp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alert_en = 1'b0;
    logic       irq_pending = 1'b0;
    logic [6:0] own_addr = 7'h2D;
    logic       ev_start = 1'b0;
    logic       ev_stop = 1'b0;
    logic       ev_addr_vld = 1'b0;
    logic [7:0] ev_addr_byte = 8'h00;
    logic       ev_reply_done = 1'b0;
    logic       ev_reply_acked = 1'b0;
    logic       alert_n;
    logic       ack_req;
    logic [7:0] reply_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] ARA_RD = 8'h19;
    localparam logic [7:0] ARA_WR = 8'h18;

    always #4 clk = ~clk;

    smb_alert_resp dut (
        .clk(clk), .rst_n(rst_n), .alert_en(alert_en), .irq_pending(irq_pending),
        .own_addr(own_addr), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_addr_vld(ev_addr_vld), .ev_addr_byte(ev_addr_byte),
        .ev_reply_done(ev_reply_done), .ev_reply_acked(ev_reply_acked),
        .alert_n(alert_n), .ack_req(ack_req), .reply_byte(reply_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; alert_en = 1'b0; irq_pending = 1'b0;
        ev_start = 0; ev_stop = 0; ev_addr_vld = 0; ev_reply_done = 0; ev_reply_acked = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_addr(input logic [7:0] b);
        ev_addr_vld = 1'b1; ev_addr_byte = b;
        @(negedge clk);
        ev_addr_vld = 1'b0;
    endtask

    task automatic send_reply(input logic acked);
        ev_reply_done = 1'b1; ev_reply_acked = acked;
        @(negedge clk);
        ev_reply_done = 1'b0; ev_reply_acked = 1'b0;
    endtask

    task automatic raise_alert();
        alert_en = 1'b1; irq_pending = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 alert_n", 8'(alert_n), 8'h01);
        chk("R1 ack_req", 8'(ack_req), 8'h00);
        chk("R1 reply_byte", reply_byte, 8'h00);
    endtask

    task automatic t_full_cycle();
        do_reset();
        alert_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 no pend", 8'(alert_n), 8'h01);
        irq_pending = 1'b1;
        @(negedge clk);
        chk("R2 alert", 8'(alert_n), 8'h00);
        send_addr(ARA_RD);
        chk("R4 ack_req", 8'(ack_req), 8'h01);
        chk("R4 reply", reply_byte, 8'h5A);
        send_reply(1'b1);
        chk("R7 alert_n", 8'(alert_n), 8'h01);
        chk("R7 ack_req", 8'(ack_req), 8'h00);
        repeat (3) @(negedge clk);
        chk("R9 held", 8'(alert_n), 8'h01);
        send_addr(ARA_RD);
        chk("R6 released", 8'(ack_req), 8'h00);
        irq_pending = 1'b0;
        @(negedge clk);
        chk("R9 low", 8'(alert_n), 8'h01);
        irq_pending = 1'b1;
        @(negedge clk);
        chk("R9 rearm", 8'(alert_n), 8'h00);
    endtask

    task automatic t_write_ignored();
        do_reset();
        raise_alert();
        send_addr(ARA_WR);
        chk("R5 write ack", 8'(ack_req), 8'h00);
        chk("R5 write alert", 8'(alert_n), 8'h00);
        send_addr(8'h5B);
        chk("R5 other ack", 8'(ack_req), 8'h00);
        chk("R5 other alert", 8'(alert_n), 8'h00);
    endtask

    task automatic t_aborts();
        do_reset();
        raise_alert();
        send_addr(ARA_RD);
        chk("R8 pre", 8'(ack_req), 8'h01);
        send_reply(1'b0);
        chk("R8 nack ack", 8'(ack_req), 8'h00);
        chk("R8 nack alert", 8'(alert_n), 8'h00);
        send_addr(ARA_RD);
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
        chk("R8 stop ack", 8'(ack_req), 8'h00);
        chk("R8 stop alert", 8'(alert_n), 8'h00);
        send_addr(ARA_RD);
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
        chk("R8 start ack", 8'(ack_req), 8'h00);
        chk("R8 start alert", 8'(alert_n), 8'h00);
    endtask

    task automatic t_disabled();
        do_reset();
        irq_pending = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 alert", 8'(alert_n), 8'h01);
        send_addr(ARA_RD);
        chk("R3 ack", 8'(ack_req), 8'h00);
        alert_en = 1'b1;
        @(negedge clk);
        chk("R2 enable", 8'(alert_n), 8'h00);
        send_addr(ARA_RD);
        chk("R11 pre", 8'(ack_req), 8'h01);
        alert_en = 1'b0;
        @(negedge clk);
        chk("R11 ack", 8'(ack_req), 8'h00);
        chk("R11 alert", 8'(alert_n), 8'h01);
    endtask

    task automatic t_pend_clear();
        do_reset();
        raise_alert();
        irq_pending = 1'b0;
        @(negedge clk);
        chk("R10 alert", 8'(alert_n), 8'h01);
        send_addr(ARA_RD);
        chk("R6 idle ack", 8'(ack_req), 8'h00);
    endtask

    initial begin
        t_reset();
        t_full_cycle();
        t_write_ignored();
        t_aborts();
        t_disabled();
        t_pend_clear();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule